// File: doc/BRIEF.md
# Low-Power Auto-Reload Event Timer

This block is an event timer for a slow counter clock. Software programs it through a small synchronous register bus that runs on the fast system clock. A 16-bit counter advances once every 2^p counter-clock cycles. When the count reaches the programmed reload value, the block records a match event, and it raises the interrupt line if that event is unmasked. A start command picks the mode. In single-shot mode the counter runs to the reload value once and then halts. In continuous mode it returns to zero and repeats, which gives a periodic tick.

Every value that matters in the counter domain crosses the clock boundary through two-flop synchronisers. The enable level does so directly. Reload updates, interrupt-enable updates and start commands each cross as a toggle. Because of this, the enable only takes hold after two counter-clock cycles. Reload and interrupt-enable writes return a completion flag once the counter domain has taken them. Each register is writable only in one enable state: reload while running, prescaler and interrupt-enable while stopped. A write in the other state is dropped. Both clock domains sample the single reset synchronously, so reset must be held across at least three counter-clock edges.

Top module: `lp_event_timer`

## Requirements
- R1: Register map by word address.
  - 0 is control: bit0 enable, bit1 single start, bit2 continuous start. The start bits act only when bit0 is set in the same write, and they read back as 0.
  - 1 is configuration: the prescaler sits in bits 11:9.
  - 2 is reload: bits 15:0.
  - 3 is interrupt-enable: bit0.
  - 4 is status: bit0 match, bit1 reload-ok, bit2 irqen-ok.
  - 5 is clear.
  - Read data appears one bus cycle after the read strobe.
  - After reset: control 0, configuration 0, reload 1, interrupt-enable 0, status 0, and irq low.
- R2: A prescaler value p from 0 to 7 makes the counter advance once every 2^p counter-clock cycles. Between advances the count holds.
- R3: In continuous mode the counter climbs from 0 to the reload value, flags a match, restarts at 0 and repeats. Successive match events are (reload+1)·2^p counter-clock cycles apart.
- R4: In single-shot mode exactly one match event occurs, and then counting stops until the next start.
- R5: A start written together with the enable leads to counting only after the enable has passed two counter-clock cycles. The first match therefore lands no earlier than (reload+1)·2^p+2 counter-clock cycles after the write, and no later than (reload+1)·2^p+4 counter-clock cycles plus 6 bus cycles after it.
- R6: A match event sets status bit0. irq is high one bus cycle after status bit0 and interrupt-enable bit0 are both 1, and low otherwise.
- R7: Writing 1 to a clear bit clears the matching status flag. Clear bits written as 0 have no effect. An event that arrives in the same cycle as the clear keeps its flag set.
- R8: A reload write is taken only while enable is 1 and the value is nonzero. The largest accepted value is 0xFFFF. Any other reload write leaves both the reload register and reload-ok unchanged.
- R9: An interrupt-enable write is taken only while enable is 0. Otherwise both the register and irqen-ok stay unchanged.
- R10: After an accepted reload or interrupt-enable write, the matching ok flag is set within 4 counter-clock cycles plus 3 bus cycles.
- R11: Writing 0 to control stops the counter, and no further match events follow.
- R12: A configuration write is taken only while enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| lp_clk | input | 1 | Slow counter clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 3-bit prescaler and a 32-bit data bus. The counter clock runs at three bus periods with a fixed phase offset, so the cost of each crossing is deterministic. Under these conditions the distance between two interrupt rising edges can be compared exactly against (reload+1)·2^p counter periods, and the vectors cover prescaler values up to the top of the range, 7. The full 16-bit reload width is checked by readback only, because a whole count at that width would not fit in the run.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;

  localparam int CTL_EN  = 0;
  localparam int CTL_ONE = 1;
  localparam int CTL_RUN = 2;

  localparam int PSC_LSB = 9;

  localparam int ST_MATCH  = 0;
  localparam int ST_RLD_OK = 1;
  localparam int ST_IEN_OK = 2;
  localparam int ST_W      = 3;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              en_q,
  output logic              rld_tgl,
  output logic              ien_tgl,
  output logic              start_tgl,
  output logic              start_cont,
  output logic [PSC_W-1:0]  psc_q,
  output logic [CNT_W-1:0]  reload_q,
  input  logic              match_s,
  input  logic              rld_ack_s,
  input  logic              ien_ack_s
);
  logic              ien_q;
  logic [ST_W-1:0]   flags;
  logic              match_seen, rld_seen, ien_seen;
  logic [ST_W-1:0]   evt, clr;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  logic wr_ctrl, wr_cfg, wr_rld, wr_ien, wr_clr;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign wr_rld  = wr_en && (addr == A_RELOAD);
  assign wr_ien  = wr_en && (addr == A_IRQEN);
  assign wr_clr  = wr_en && (addr == A_CLR);

  logic rld_take, ien_take, cfg_take, start_req;
  assign rld_take  = wr_rld && en_q && (wdata[CNT_W-1:0] != '0);
  assign ien_take  = wr_ien && !en_q;
  assign cfg_take  = wr_cfg && !en_q;
  assign start_req = wr_ctrl && wdata[CTL_EN] && (wdata[CTL_ONE] || wdata[CTL_RUN]);

  always_comb begin
    evt = '0;
    evt[ST_MATCH]  = match_s ^ match_seen;
    evt[ST_RLD_OK] = rld_ack_s ^ rld_seen;
    evt[ST_IEN_OK] = ien_ack_s ^ ien_seen;
  end
  assign clr = wr_clr ? wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      psc_q      <= '0;
      reload_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
      ien_q      <= 1'b0;
      rld_tgl    <= 1'b0;
      ien_tgl    <= 1'b0;
      start_tgl  <= 1'b0;
      start_cont <= 1'b0;
      flags      <= '0;
      match_seen <= 1'b0;
      rld_seen   <= 1'b0;
      ien_seen   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata[CTL_EN];
      if (start_req) begin
        start_tgl  <= ~start_tgl;
        start_cont <= wdata[CTL_RUN];
      end
      if (cfg_take) psc_q <= wdata[PSC_LSB +: PSC_W];
      if (rld_take) begin
        reload_q <= wdata[CNT_W-1:0];
        rld_tgl  <= ~rld_tgl;
      end
      if (ien_take) begin
        ien_q   <= wdata[0];
        ien_tgl <= ~ien_tgl;
      end
      match_seen <= match_s;
      rld_seen   <= rld_ack_s;
      ien_seen   <= ien_ack_s;
      flags      <= (flags & ~clr) | evt;
      irq        <= flags[ST_MATCH] & ien_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:   rd_mux[CTL_EN] = en_q;
      A_CFG:    rd_mux[PSC_LSB +: PSC_W] = psc_q;
      A_RELOAD: rd_mux[CNT_W-1:0] = reload_q;
      A_IRQEN:  rd_mux[0] = ien_q;
      A_STAT:   rd_mux[ST_W-1:0] = flags;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R8
  reload_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_RELOAD && !en_q) |=> $stable(reload_q));

  // R9
  irqen_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_IRQEN && en_q) |=> $stable(ien_q));

  // R12
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CFG && en_q) |=> $stable(psc_q));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLR && !wdata[ST_MATCH] && flags[ST_MATCH]) |=> flags[ST_MATCH]);
endmodule

// File: rtl/lpt_core.sv
module lpt_core #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             lclk,
  input  logic             rst,
  input  logic             en_s,
  input  logic             rld_tgl_s,
  input  logic             ien_tgl_s,
  input  logic             start_tgl_s,
  input  logic             start_cont,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] reload_bus,
  output logic             rld_ack,
  output logic             ien_ack,
  output logic             match_tgl
);
  localparam int PRE_W = (1 << PSC_W) - 1;
  localparam logic [PRE_W:0]   SPAN_ONE = {{PRE_W{1'b0}}, 1'b1};
  localparam logic [PRE_W-1:0] PRE_ONE  = {{(PRE_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] div_max, pre_q;
  logic [CNT_W-1:0] cnt_q, reload_cur;
  logic             start_seen, rld_seen, ien_seen;
  logic             pend, pend_cont, running, cont_q;
  logic             start_evt, tick, hit;

  assign span      = SPAN_ONE << psc;
  assign div_max   = PRE_W'(span - SPAN_ONE);
  assign tick      = (pre_q == div_max);
  assign hit       = running && tick && (cnt_q >= reload_cur);
  assign start_evt = start_tgl_s ^ start_seen;
  assign rld_ack   = rld_seen;
  assign ien_ack   = ien_seen;

  always_ff @(posedge lclk) begin
    if (rst) begin
      start_seen <= 1'b0;
      rld_seen   <= 1'b0;
      ien_seen   <= 1'b0;
      reload_cur <= CNT_ONE;
      pend       <= 1'b0;
      pend_cont  <= 1'b0;
      running    <= 1'b0;
      cont_q     <= 1'b0;
      cnt_q      <= '0;
      pre_q      <= '0;
      match_tgl  <= 1'b0;
    end else begin
      start_seen <= start_tgl_s;
      rld_seen   <= rld_tgl_s;
      ien_seen   <= ien_tgl_s;
      if (rld_tgl_s != rld_seen) reload_cur <= reload_bus;

      if (start_evt) begin
        pend      <= 1'b1;
        pend_cont <= start_cont;
      end else if (pend || !en_s) begin
        pend <= 1'b0;
      end

      if (!en_s) begin
        running <= 1'b0;
        cnt_q   <= '0;
        pre_q   <= '0;
      end else if (pend) begin
        running <= 1'b1;
        cont_q  <= pend_cont;
        cnt_q   <= '0;
        pre_q   <= '0;
      end else if (running) begin
        pre_q <= tick ? '0 : pre_q + PRE_ONE;
        if (hit) begin
          cnt_q     <= '0;
          match_tgl <= ~match_tgl;
          if (!cont_q) running <= 1'b0;
        end else if (tick) begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
    end
  end

  // R11
  stop_clears_chk: assert property (@(posedge lclk) disable iff (rst)
    !en_s |=> (!running && cnt_q == '0));

  // R4
  single_halt_chk: assert property (@(posedge lclk) disable iff (rst)
    (hit && !cont_q) |=> !running);

  // R3
  wrap_zero_chk: assert property (@(posedge lclk) disable iff (rst)
    (hit && cont_q && en_s) |=> (running && cnt_q == '0));

  // R2
  prescale_hold_chk: assert property (@(posedge lclk) disable iff (rst)
    (running && !tick && en_s && !pend) |=> $stable(cnt_q));
endmodule

// File: rtl/lp_event_timer.sv
module lp_event_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int FWD_W = 4;
  localparam int BCK_W = 3;

  logic             en_q, rld_tgl, ien_tgl, start_tgl, start_cont;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] reload_q;
  logic [FWD_W-1:0] fwd_s;
  logic [BCK_W-1:0] bck_s;
  logic             rld_ack, ien_ack, match_tgl;

  lpt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .en_q(en_q),
    .rld_tgl(rld_tgl), .ien_tgl(ien_tgl), .start_tgl(start_tgl),
    .start_cont(start_cont), .psc_q(psc_q), .reload_q(reload_q),
    .match_s(bck_s[0]), .rld_ack_s(bck_s[1]), .ien_ack_s(bck_s[2])
  );

  lpt_sync #(.WIDTH(FWD_W), .STAGES(SYNC_N)) u_to_lp (
    .clk(lp_clk), .rst(rst),
    .d({start_tgl, ien_tgl, rld_tgl, en_q}), .q(fwd_s)
  );

  lpt_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .lclk(lp_clk), .rst(rst), .en_s(fwd_s[0]), .rld_tgl_s(fwd_s[1]),
    .ien_tgl_s(fwd_s[2]), .start_tgl_s(fwd_s[3]), .start_cont(start_cont),
    .psc(psc_q), .reload_bus(reload_q), .rld_ack(rld_ack),
    .ien_ack(ien_ack), .match_tgl(match_tgl)
  );

  lpt_sync #(.WIDTH(BCK_W), .STAGES(SYNC_N)) u_to_bus (
    .clk(clk), .rst(rst),
    .d({ien_ack, rld_ack, match_tgl}), .q(bck_s)
  );

  // R5
  enable_delay_chk: assert property (@(posedge lp_clk) disable iff (rst)
    $rose(fwd_s[0]) |-> $past(en_q, 2));
endmodule

// File: tb/lp_event_timer_test.sv
`timescale 1ns/1ps
module lp_event_timer_test;
  localparam int LP_NS = 24;
  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_RELOAD = 3'd2,
                         A_IRQEN = 3'd3, A_STAT = 3'd4, A_CLR = 3'd5;
  localparam int NVEC = 7;
  // {continuous, prescaler, reload}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 16'd1},
    {1'b1, 3'd0, 16'd4},
    {1'b1, 3'd2, 16'd9},
    {1'b1, 3'd7, 16'd3},
    {1'b0, 3'd1, 16'd6},
    {1'b0, 3'd3, 16'd2},
    {1'b1, 3'd5, 16'd1}
  };

  logic clk, rst, lp_clk, wr_en, rd_en, irq;
  logic [2:0] addr;
  logic [31:0] wdata, rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  lp_event_timer uut (
    .clk(clk), .rst(rst), .lp_clk(lp_clk), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial begin clk = 0; forever #4 clk = ~clk; end
  initial begin lp_clk = 0; #2; forever #12 lp_clk = ~lp_clk; end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input longint act, input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(input int limit, output bit got, output longint t);
    got = 0; t = 0;
    for (int i = 0; i < limit; i++) begin @(negedge clk); if (!irq) break; end
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irq) begin got = 1; t = $time; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    bit got;
    longint t0, t1, ts, per;
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; rst = 1;
    idle(20);
    rst = 0;
    idle(4);

    // R1 reset state
    bus_rd(A_CTRL, r);   check("R1 ctrl reset", r, 0);
    bus_rd(A_CFG, r);    check("R1 cfg reset", r, 0);
    bus_rd(A_RELOAD, r); check("R1 reload reset", r, 1);
    bus_rd(A_IRQEN, r);  check("R1 irqen reset", r, 0);
    bus_rd(A_STAT, r);   check("R1 status reset", r, 0);
    check("R1 irq reset", irq, 0);

    // R8 reload write while disabled ignored
    bus_wr(A_RELOAD, 32'd7); idle(12);
    bus_rd(A_RELOAD, r); check("R8 reload held while disabled", r, 1);
    bus_rd(A_STAT, r);   check("R8 no reload-ok while disabled", r[1], 0);

    // R12 config write while enabled ignored
    bus_wr(A_CTRL, 32'd1);
    bus_wr(A_CFG, 32'd3 << 9);
    bus_rd(A_CFG, r); check("R12 cfg held while enabled", r, 0);

    // R9 irqen write while enabled ignored
    bus_wr(A_IRQEN, 32'd1); idle(12);
    bus_rd(A_IRQEN, r); check("R9 irqen held while enabled", r, 0);
    bus_rd(A_STAT, r);  check("R9 no irqen-ok while enabled", r[2], 0);

    // R8 zero reload ignored, full-width reload accepted
    bus_wr(A_RELOAD, 32'd0); idle(12);
    bus_rd(A_RELOAD, r); check("R8 zero reload ignored", r, 1);
    bus_rd(A_STAT, r);   check("R8 zero reload no ok", r[1], 0);
    bus_wr(A_RELOAD, 32'hFFFF); idle(12);
    bus_rd(A_RELOAD, r); check("R8 max reload", r, 32'hFFFF);
    bus_rd(A_STAT, r);   check("R10 reload-ok set", r[1], 1);
    bus_wr(A_CLR, 32'd2);
    bus_rd(A_STAT, r);   check("R7 reload-ok cleared", r[1], 0);

    // R1 start bits read back as zero
    bus_wr(A_CTRL, 32'd3);
    bus_rd(A_CTRL, r); check("R1 start bits read zero", r, 1);
    bus_wr(A_CTRL, 32'd0); idle(40);
    bus_wr(A_CLR, 32'd7);

    // vector table: R2, R3, R4, R10
    for (int v = 0; v < NVEC; v++) begin
      logic cont;
      logic [2:0] p;
      logic [15:0] rl;
      int cyc;
      {cont, p, rl} = VEC[v];
      per = longint'((rl + 1) << p) * LP_NS;
      cyc = int'(per / 8) + 200;
      bus_wr(A_CTRL, 32'd0); idle(40);
      bus_wr(A_CLR, 32'd7);
      bus_wr(A_CFG, 32'(p) << 9);
      bus_wr(A_IRQEN, 32'd1); idle(12);
      bus_rd(A_STAT, r); check("R10 irqen-ok set", r[2], 1);
      bus_wr(A_CTRL, 32'd1);
      bus_wr(A_RELOAD, 32'(rl)); idle(12);
      bus_rd(A_STAT, r); check("R10 reload-ok in vector", r[1], 1);
      bus_wr(A_CLR, 32'd6);
      bus_wr(A_CTRL, cont ? 32'd5 : 32'd3);
      wait_rise(cyc, got, t0);
      check("R2 first match seen", got, 1);
      bus_wr(A_CLR, 32'd1);
      if (cont) begin
        wait_rise(cyc, got, t1);
        check("R3 period (R2 prescale)", t1 - t0, per);
      end else begin
        idle(3 * cyc);
        bus_rd(A_STAT, r); check("R4 single shot no rematch", r[0], 0);
        check("R4 irq stays low", irq, 0);
      end
    end

    // R5 enable delay and first-match latency
    bus_wr(A_CTRL, 32'd0); idle(40);
    bus_wr(A_CFG, 32'd0);
    bus_wr(A_CTRL, 32'd1);
    bus_wr(A_RELOAD, 32'd5); idle(12);
    bus_wr(A_CTRL, 32'd0); idle(40);
    bus_wr(A_CLR, 32'd7);
    bus_wr(A_CTRL, 32'd5);
    ts = $time - 4;
    wait_rise(400, got, t0);
    check_range("R5 first match latency", t0 - ts, 8 * LP_NS, 10 * LP_NS + 48);

    // R11 disable stops counting
    bus_wr(A_CTRL, 32'd0); idle(40);
    bus_wr(A_CLR, 32'd7); idle(200);
    bus_rd(A_STAT, r); check("R11 no match after stop", r[0], 0);

    // R6 masked flag, R7 zero clear bits
    bus_wr(A_IRQEN, 32'd0);
    bus_wr(A_CTRL, 32'd1);
    bus_wr(A_RELOAD, 32'd4); idle(12);
    bus_wr(A_CLR, 32'd7);
    bus_wr(A_CTRL, 32'd3); idle(60);
    bus_rd(A_STAT, r); check("R6 match flag set", r[0], 1);
    check("R6 irq masked", irq, 0);
    bus_wr(A_CLR, 32'd6);
    bus_rd(A_STAT, r); check("R7 zero clear bit no effect", r[0], 1);
    bus_wr(A_CLR, 32'd1);
    bus_rd(A_STAT, r); check("R7 match cleared", r[0], 0);

    // R6 unmasked interrupt
    bus_wr(A_CTRL, 32'd0); idle(40);
    bus_wr(A_IRQEN, 32'd1);
    bus_wr(A_CTRL, 32'd3); idle(60);
    check("R6 irq asserted", irq, 1);
    bus_wr(A_CLR, 32'd1); idle(3);
    check("R6 irq drops after clear", irq, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule